// File: doc/BRIEF.md
# Framed Serial Sample Transmitter

This block is the transmit side of a measurement converter's serial port. It is a master: from the master clock it makes its own bit clock, a frame-start pulse and a data line. Each time a new voltage/current sample pair is strobed in, it sends one fixed frame. The frame has a one-bit-period start pulse and then 96 gated bit clocks. The voltage word comes first, then the current word, then 64 zero bits. Between frames the bit clock rests low.

The incoming pair is captured into a shadow register. A strobe that arrives while a frame is on the line waits as a pending request, and a later strobe overwrites the pending pair. The frame being sent is never disturbed. A rate-select input picks a bit clock of one eighth or one quarter of the master clock, and it is read once at the start of each frame. The port drives no pads itself. It provides the three line values plus one registered output-enable, which the pad ring uses to tristate the lines.

Top module: `sport_frame_tx`

## Requirements
- R1: The bit clock period is 8 master clocks when `rate_fast` is 0 and 4 when it is 1, each half lasting half the period. `rate_fast` is sampled on the clock edge that starts a frame and holds for that whole frame.
- R2: `fso` is high for exactly one bit-clock period per frame, and `sclk` stays low during that time. The first `sclk` rise follows the fall of `fso` by half a bit period.
- R3: After `fso` falls, `sclk` rises exactly 96 times, then stays low until the next frame.
- R4: Bits are valid at `sclk` rising edges, MSB first: the 16-bit voltage word, then the 16-bit current word, then 64 zero bits.
- R5: `sdo` changes only at clock edges that leave `sclk` low, and never while `sclk` is high.
- R6: `port_oe` equals `ser_en` as sampled on the previous master clock edge. Frame timing does not depend on `ser_en`.
- R7: A synchronous active-high `rst` forces `sclk`, `fso`, `sdo` and `port_oe` to 0 and drops any pending request.
- R8: When the port is idle, a `load` pulse captures `volt_in`/`curr_in`, and `fso` rises on the next clock edge.
- R9: A `load` during a frame is held. The frame carries the pair that was captured when it started, and the most recent pair captured meanwhile is sent next. That next frame's `fso` rises one master clock after the final `sclk` fall.
- R10: `sdo` is 0 while the port is idle and while `fso` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_fast | input | 1 | 1: bit clock = clk/4, 0: clk/8 |
| ser_en | input | 1 | Line enable request |
| load | input | 1 | New sample pair strobe |
| volt_in | input | 16 | Voltage sample, two's complement |
| curr_in | input | 16 | Current sample, two's complement |
| sclk | output | 1 | Bit clock line value |
| fso | output | 1 | Frame-start line value |
| sdo | output | 1 | Serial data line value |
| port_oe | output | 1 | Drive enable for the three lines |

## Verification
Two functions can meet in one clock edge. A sample strobe can be captured into the shadow register on the very edge where the idle port copies that shadow into its shift register and starts a frame. A strobe can also land on the edge that ends a frame, and that edge has to set the pending flag that the next edge starts from. Random strobes arriving at any cycle, some of them closely spaced, together with random rate and enable flips, provoke both cases many times. A bench model of the pending flag and the shadow pair predicts the exact cycle each `fso` should rise. It also predicts the 96 bits each frame must carry, so both a lost or early frame and a corrupted pair are detected.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] volt;
        logic [SAMPLE_W-1:0] curr;
    } sample_pair_t;

    // master clocks in one half of the bit clock
    function automatic int half_len(input logic fast, input int slow_div, input int fast_div);
        return fast ? fast_div / 2 : slow_div / 2;
    endfunction

endpackage

// File: rtl/sport_clkdiv.sv
module sport_clkdiv
    import sport_pkg::*;
#(
    parameter int SLOW_DIV = 8,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic half_end
);
    localparam int MAX_HALF = ((SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV) / 2;
    localparam int PH_W     = $clog2(MAX_HALF + 1);

    logic [PH_W-1:0] ph;
    int              limit;

    always_comb begin
        limit    = half_len(fast, SLOW_DIV, FAST_DIV);
        half_end = run && (ph == PH_W'(limit - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph <= '0;
        end else if (half_end) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end
endmodule

// File: rtl/sport_sequencer.sv
module sport_sequencer
    import sport_pkg::*;
#(
    parameter int FRAME_BITS = 96
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              pend,
    input  logic                              rate_fast,
    input  logic                              half_end,
    output seq_state_e                        state,
    output logic [$clog2(2*FRAME_BITS)-1:0]   hcnt,
    output logic                              fast_q,
    output logic                              start,
    output logic                              shift_step
);
    localparam int HALVES = 2 * FRAME_BITS;
    localparam int HC_W   = $clog2(HALVES);

    assign start      = (state == ST_IDLE) && pend;
    assign shift_step = (state == ST_SHIFT) && half_end && hcnt[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            hcnt   <= '0;
            fast_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pend) begin
                        state  <= ST_SYNC;
                        hcnt   <= '0;
                        fast_q <= rate_fast;
                    end
                end
                ST_SYNC: begin
                    if (half_end) begin
                        if (hcnt[0]) begin
                            state <= ST_SHIFT;
                            hcnt  <= '0;
                        end else begin
                            hcnt <= hcnt + 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (half_end) begin
                        if (hcnt == HC_W'(HALVES - 1)) begin
                            state <= ST_IDLE;
                            hcnt  <= '0;
                        end else begin
                            hcnt <= hcnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    hcnt  <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter
    import sport_pkg::*;
#(
    parameter int FRAME_BITS = 96
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] volt_in,
    input  logic [SAMPLE_W-1:0] curr_in,
    input  logic                start,
    input  logic                shift_step,
    output logic                pend,
    output logic                msb
);
    localparam int PAD_BITS = FRAME_BITS - 2 * SAMPLE_W;

    sample_pair_t          shadow;
    logic [FRAME_BITS-1:0] sr;

    assign msb = sr[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (load) begin
            shadow.volt <= volt_in;
            shadow.curr <= curr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (load) begin
            pend <= 1'b1;
        end else if (start) begin
            pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (start) begin
            sr <= {shadow.volt, shadow.curr, {PAD_BITS{1'b0}}};
        end else if (shift_step) begin
            sr <= {sr[FRAME_BITS-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sport_frame_tx.sv
module sport_frame_tx
    import sport_pkg::*;
#(
    parameter int FRAME_WORDS = 6,
    parameter int SLOW_DIV    = 8,
    parameter int FAST_DIV    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rate_fast,
    input  logic                ser_en,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] volt_in,
    input  logic [SAMPLE_W-1:0] curr_in,
    output logic                sclk,
    output logic                fso,
    output logic                sdo,
    output logic                port_oe
);
    localparam int FRAME_BITS = FRAME_WORDS * SAMPLE_W;
    localparam int HC_W       = $clog2(2 * FRAME_BITS);

    seq_state_e      state;
    logic [HC_W-1:0] hcnt;
    logic            fast_q;
    logic            start;
    logic            shift_step;
    logic            half_end;
    logic            pend;
    logic            msb;

    sport_clkdiv #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) i_clkdiv (
        .clk      (clk),
        .rst      (rst),
        .run      (state != ST_IDLE),
        .fast     (fast_q),
        .half_end (half_end)
    );

    sport_sequencer #(
        .FRAME_BITS (FRAME_BITS)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .pend       (pend),
        .rate_fast  (rate_fast),
        .half_end   (half_end),
        .state      (state),
        .hcnt       (hcnt),
        .fast_q     (fast_q),
        .start      (start),
        .shift_step (shift_step)
    );

    sport_shifter #(
        .FRAME_BITS (FRAME_BITS)
    ) i_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .volt_in    (volt_in),
        .curr_in    (curr_in),
        .start      (start),
        .shift_step (shift_step),
        .pend       (pend),
        .msb        (msb)
    );

    assign sclk = (state == ST_SHIFT) && hcnt[0];
    assign fso  = (state == ST_SYNC);
    assign sdo  = (state == ST_SHIFT) && msb;

    always_ff @(posedge clk) begin
        if (rst) begin
            port_oe <= 1'b0;
        end else begin
            port_oe <= ser_en;
        end
    end
endmodule

// File: rtl/sport_frame_tx_chk.sv
module sport_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic ser_en,
    input logic sclk,
    input logic fso,
    input logic sdo,
    input logic port_oe
);
    // R2
    fso_clk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fso |-> !sclk);

    // R10
    fso_data_low_chk: assert property (@(posedge clk) disable iff (rst)
        fso |-> !sdo);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdo));

    // R2
    sync_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fso) |-> !sclk);

    // R3
    frame_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fso) |-> !$past(sclk));

    // R6
    oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (port_oe == $past(ser_en)));
endmodule

bind sport_frame_tx sport_frame_tx_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .ser_en  (ser_en),
    .sclk    (sclk),
    .fso     (fso),
    .sdo     (sdo),
    .port_oe (port_oe)
);

// File: tb/test_sport_frame_tx.sv
module test_sport_frame_tx;
    localparam int SLOW_H = 4;
    localparam int FAST_H = 2;
    localparam int NBITS  = 96;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rate_fast = 1'b0;
    logic        ser_en = 1'b0;
    logic        load = 1'b0;
    logic [15:0] volt_in = '0;
    logic [15:0] curr_in = '0;
    logic        sclk, fso, sdo, port_oe;

    int vec = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sport_frame_tx i_sport_frame_tx (
        .clk       (clk),
        .rst       (rst),
        .rate_fast (rate_fast),
        .ser_en    (ser_en),
        .load      (load),
        .volt_in   (volt_in),
        .curr_in   (curr_in),
        .sclk      (sclk),
        .fso       (fso),
        .sdo       (sdo),
        .port_oe   (port_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    endtask

    // inputs as they will be sampled on the next rising edge
    logic        s_rst = 1'b1, s_load = 1'b0, s_rate = 1'b0, s_en = 1'b0;
    logic [15:0] s_v = '0, s_c = '0;
    logic        p_fso = 1'b0, p_sclk = 1'b0;
    // model of pending request and shadow pair
    logic        m_pend = 1'b0, m_idle = 1'b1, in_frame = 1'b0;
    logic [31:0] m_shadow = '0;
    logic [95:0] m_frame = '0, rx = '0;
    logic        fso_rise, want;
    int          m_h = SLOW_H;
    int          cyc = 0, rise_cyc = 0, ref_cyc = 0, bits = 0, frames = 0;

    always @(negedge clk) begin
        cyc++;
        if (s_rst) begin
            // R7
            chk({sclk, fso, sdo, port_oe} == 4'b0, "R7", {sclk, fso, sdo, port_oe}, 0);
            m_pend = 1'b0; m_idle = 1'b1; in_frame = 1'b0; bits = 0;
        end else begin
            fso_rise = fso && !p_fso;
            want     = m_idle && m_pend;
            // R8 R9: frame starts exactly when model says idle with pending pair
            chk(fso_rise == want, "R8/R9 start", fso_rise, want);
            // R6
            chk(port_oe == s_en, "R6", port_oe, s_en);
            if (fso_rise) begin
                m_frame  = {m_shadow, 64'd0};
                m_pend   = 1'b0;
                m_idle   = 1'b0;
                m_h      = s_rate ? FAST_H : SLOW_H;
                rise_cyc = cyc;
            end
            if (fso) begin
                // R2 R10
                chk(!sclk && !sdo, "R2/R10 fso", {sclk, sdo}, 0);
            end
            if (!fso && p_fso) begin
                // R2
                chk(cyc - rise_cyc == 2 * m_h, "R2 width", cyc - rise_cyc, 2 * m_h);
                in_frame = 1'b1;
                bits     = 0;
                ref_cyc  = cyc - m_h;
            end
            if (!in_frame && !fso) begin
                // R3 R10
                chk(!sclk && !sdo, "R3/R10 idle", {sclk, sdo}, 0);
            end
            if (in_frame) begin
                if (sclk && !p_sclk) begin
                    // R1
                    chk(cyc - ref_cyc == 2 * m_h, "R1 period", cyc - ref_cyc, 2 * m_h);
                    ref_cyc = cyc;
                    rx      = {rx[94:0], sdo};
                    bits++;
                end
                if (!sclk && p_sclk && bits == NBITS) begin
                    // R4 R9
                    chk(rx == m_frame, "R4 content", rx, m_frame);
                    in_frame = 1'b0;
                    m_idle   = 1'b1;
                    frames++;
                end
            end
            if (s_load) begin
                m_shadow = {s_v, s_c};
                m_pend   = 1'b1;
            end
        end
        p_fso  = fso;
        p_sclk = sclk;
        s_rst  = rst;
        s_load = load;
        s_rate = rate_fast;
        s_en   = ser_en;
        s_v    = volt_in;
        s_c    = curr_in;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [15:0] v, input logic [15:0] c);
        volt_in = v;
        curr_in = c;
        load    = 1'b1;
        tick(1);
        load    = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(m_idle && !m_pend)) tick(1);
        tick(3);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        tick(4);
        rst = 1'b0;
        ser_en = 1'b1;
        tick(3);
        // R8: single frame at slow rate
        push(16'h1234, 16'hABCD);
        wait_idle();
        // R1 R9: fast rate, several updates during one frame, latest wins
        rate_fast = 1'b1;
        push(16'h8000, 16'h7FFF);
        tick(40);
        push(16'hFFFF, 16'h0001);
        tick(20);
        push(16'h5555, 16'hAAAA);
        rate_fast = 1'b0;   // R1: rate change mid-frame must not affect it
        wait_idle();
        // R6: disable lines during a frame
        push(16'h0F0F, 16'hF0F0);
        tick(30);
        ser_en = 1'b0;
        tick(30);
        ser_en = 1'b1;
        wait_idle();
        // R7: reset in the middle of a frame with a pending pair
        push(16'hDEAD, 16'hBEEF);
        tick(50);
        push(16'h1111, 16'h2222);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(900);
        // back-to-back strobes
        push(16'h7FFF, 16'h8000);
        push(16'h0001, 16'hFFFE);
        wait_idle();
        // random traffic
        for (int k = 0; k < 60000; k++) begin
            if ($urandom % 8 == 0) rate_fast = ~rate_fast;
            if ($urandom % 150 == 0) ser_en = ~ser_en;
            if ($urandom % 220 == 0) push(16'($urandom), 16'($urandom));
            else tick(1);
        end
        wait_idle();
        // R4: enough complete frames were seen
        chk(frames >= 40, "R4 frame count", frames, 40);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R3 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule